// File: doc/BRIEF.md
# Transmit pad and FCS inserter

This block sits in the transmit path of an Ethernet MAC, between the frame source and the byte serializer. Outgoing frames arrive as a byte stream with valid, last and ready handshakes. Depending on a 3-bit pad mode, the block zero-pads short frames. It then appends the IEEE 802.3 CRC-32 frame check sequence. It can instead leave a frame unchanged and check the FCS that the frame already ends with. When each frame finishes, the block emits a one-cycle status vector.

The frame may optionally start with a 4-byte leading header. This header is forwarded unchanged but is excluded from the CRC, the pad target and every length count. A length guard aborts frames that exceed a programmed maximum. An optional length check compares a type/length value of 1500 or less against the real payload size. Configuration inputs are sampled live and must be held stable while a frame is in flight.

Top module: `tx_fcs_inserter`

## Requirements
- R1: With CRC append on, pad mode 3'b001 zero-pads the body (bytes after any leading header, before the FCS) up to 60 bytes, then appends the FCS.
- R2: With CRC append on, pad modes 3'b011 and 3'b111 zero-pad the body up to 64 bytes, then append the FCS; longer bodies are not altered.
- R3: With CRC append on, pad mode 3'b101 reads body bytes 12 and 13 as a big-endian type field. A frame with value 0x8100 is padded to 64 bytes; any other frame, including one too short to hold both bytes, is padded to 60.
- R4: Pad modes with bit 0 clear (3'b000, 3'b010, 3'b100, 3'b110) never pad, and no pad mode pads while CRC append is off.
- R5: With CRC append on, the block appends the complement of the reflected CRC-32 (polynomial 0xEDB88320, seed 0xFFFFFFFF) over body and pad bytes, least significant byte first, and marks only the last FCS byte with m_last_o.
- R6: With CRC append off, nothing is appended and m_last_o follows the input. The status CRC-error bit is set exactly when the final four body bytes are not the valid FCS of the preceding bytes.
- R7: With header mode on, the first 4 input bytes pass through unchanged. They are left out of the CRC, the pad target, the length limit and the status length.
- R8: With huge-frame mode off, the first body byte that would push the frame (body plus FCS, appended or carried) beyond max_len_i is dropped along with the rest of the input frame. No pad or FCS follows. Status reports abort=1, and its length is the number of body bytes already forwarded.
- R9: With huge-frame mode on, frames longer than max_len_i are forwarded whole.
- R10: With length check on and a type/length value of 1500 (0x05DC) or less, the status length-error bit is set when that value differs from the byte count between the 14-byte MAC header and the FCS, pad included. Values above 1500 are never flagged.
- R11: stat_valid_o pulses for exactly one cycle per frame, in the cycle after the final output handshake or after the last input byte of an aborted frame. stat_len_o gives the body length including pad and FCS.
- R12: Body bytes pass through with s_ready_o equal to m_ready_i. Pad and FCS bytes are held stable on m_data_o while m_ready_i is low.
- R13: After reset, m_valid_o and stat_valid_o are low and the block waits for a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s_data_i | input | 8 | Input frame byte |
| s_valid_i | input | 1 | Input byte valid |
| s_last_i | input | 1 | Input byte is the last of the frame |
| s_ready_o | output | 1 | Block accepts the input byte |
| m_data_o | output | 8 | Output frame byte |
| m_valid_o | output | 1 | Output byte valid |
| m_last_o | output | 1 | Output byte is the last of the frame |
| m_ready_i | input | 1 | Downstream accepts the output byte |
| pad_mode_i | input | 3 | Pad mode code |
| crc_app_i | input | 1 | Append FCS (1) or check carried FCS (0) |
| hdr_en_i | input | 1 | Frames start with a 4-byte header excluded from CRC |
| huge_en_i | input | 1 | Disable the maximum length guard |
| len_chk_i | input | 1 | Enable the type/length comparison |
| max_len_i | input | LEN_W | Maximum frame length including FCS |
| stat_valid_o | output | 1 | Status vector valid pulse |
| stat_len_o | output | LEN_W | Body bytes sent, pad and FCS included |
| stat_crc_err_o | output | 1 | Carried FCS did not match |
| stat_len_err_o | output | 1 | Type/length value disagrees with payload size |
| stat_abort_o | output | 1 | Frame aborted by the length guard |

## Verification
Each pad mode is driven with frames on either side of its target. The bench compares a 20- or 30-byte body against a 70-byte one, and in VLAN-sniffing mode it tries a 0x8100 type, a plain type, and a frame that ends between the two type bytes. This separates the 60-byte target from the 64-byte one, and sniffing from fixed targets. Carried-FCS frames are sent with both a valid and a corrupted check sequence. Length-field frames use values that match, that miss, exactly 1500 and exactly 1501. Length-guard frames sit at the limit, one byte over it, and well over it (which exercises the drop path). A subset runs with downstream back-pressure, so that stalls inside pad and FCS emission are exposed as corrupted or duplicated bytes.

// File: rtl/tx_fcs_pkg.sv
package tx_fcs_pkg;
  localparam int unsigned HDR_BYTES   = 4;
  localparam int unsigned TYPE_OFS    = 12;
  localparam int unsigned MAC_HDR     = 14;
  localparam int unsigned FCS_BYTES   = 4;
  localparam int unsigned LEN_MAX_VAL = 1500;
  localparam logic [15:0] VLAN_TPID   = 16'h8100;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  typedef enum logic [2:0] {
    ST_BODY,
    ST_PAD,
    ST_FCS,
    ST_DROP,
    ST_STAT
  } tx_state_e;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/tx_crc32.sv
module tx_crc32
  import tx_fcs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o,
  output logic [31:0] crc_nxt_o
);
  logic [31:0] crc_q;

  assign crc_nxt_o = en_i ? crc_byte(crc_q, data_i) : crc_q;
  assign crc_o     = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= CRC_SEED;
    else if (clr_i) crc_q <= CRC_SEED;
    else if (en_i)  crc_q <= crc_nxt_o;
  end
endmodule

// File: rtl/tx_pad_sel.sv
module tx_pad_sel #(
  parameter int unsigned TGT_W     = 8,
  parameter int unsigned SHORT_PAD = 60,
  parameter int unsigned LONG_PAD  = 64
) (
  input  logic [2:0]       mode_i,
  input  logic             app_i,
  input  logic             vlan_i,
  output logic [TGT_W-1:0] tgt_o
);
  localparam logic [TGT_W-1:0] T_SHORT = TGT_W'(SHORT_PAD);
  localparam logic [TGT_W-1:0] T_LONG  = TGT_W'(LONG_PAD);

  // bit 0 enables padding; bits 2:1 pick target
  always_comb begin
    if (!app_i || !mode_i[0]) tgt_o = '0;
    else begin
      unique case (mode_i[2:1])
        2'b00:   tgt_o = T_SHORT;
        2'b10:   tgt_o = vlan_i ? T_LONG : T_SHORT;
        default: tgt_o = T_LONG;
      endcase
    end
  end
endmodule

// File: rtl/tx_fcs_inserter.sv
module tx_fcs_inserter
  import tx_fcs_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned TGT_W     = 8,
  parameter int unsigned SHORT_PAD = 60,
  parameter int unsigned LONG_PAD  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  input  logic             s_last_i,
  output logic             s_ready_o,
  output logic [7:0]       m_data_o,
  output logic             m_valid_o,
  output logic             m_last_o,
  input  logic             m_ready_i,
  input  logic [2:0]       pad_mode_i,
  input  logic             crc_app_i,
  input  logic             hdr_en_i,
  input  logic             huge_en_i,
  input  logic             len_chk_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic             stat_valid_o,
  output logic [LEN_W-1:0] stat_len_o,
  output logic             stat_crc_err_o,
  output logic             stat_len_err_o,
  output logic             stat_abort_o
);
  localparam int unsigned HDR_CW = $clog2(HDR_BYTES + 1);

  tx_state_e        state_q;
  logic [HDR_CW-1:0] hdr_cnt_q;
  logic [LEN_W-1:0] body_cnt_q;
  logic [7:0]       typ_hi_q;
  logic [15:0]      typ_q;
  logic             typ_ok_q;
  logic [1:0]       fcs_idx_q;
  logic [TGT_W-1:0] pad_tgt_q;
  logic [LEN_W-1:0] pend_len_q;
  logic             pend_crc_err_q, pend_len_err_q, pend_abort_q;

  logic        in_hdr, over, s_fire, m_fire;
  logic [31:0] fcs_room, n_now, eff;
  logic        typ_at_end, typ_cur_ok, vlan, need_pad;
  logic [15:0] typ_cur;
  logic [TGT_W-1:0] pad_tgt;
  logic        len_err_now, crc_err_now;
  logic        crc_en, crc_clr;
  logic [31:0] crc_q, crc_nxt, fcs_word;

  assign in_hdr   = hdr_en_i && (32'(hdr_cnt_q) < HDR_BYTES);
  assign fcs_room = crc_app_i ? FCS_BYTES : 32'd0;
  assign over     = (state_q == ST_BODY) && !huge_en_i && !in_hdr &&
                    (32'(body_cnt_q) + 32'd1 + fcs_room > 32'(max_len_i));
  assign s_fire   = s_valid_i && s_ready_o;
  assign m_fire   = m_valid_o && m_ready_i;

  // type field may complete on the current byte
  assign typ_at_end = !in_hdr && (32'(body_cnt_q) == TYPE_OFS + 1);
  assign typ_cur_ok = typ_ok_q || typ_at_end;
  assign typ_cur    = typ_ok_q ? typ_q : {typ_hi_q, s_data_i};
  assign vlan       = typ_cur_ok && (typ_cur == VLAN_TPID);
  assign n_now      = 32'(body_cnt_q) + (in_hdr ? 32'd0 : 32'd1);

  tx_pad_sel #(
    .TGT_W    (TGT_W),
    .SHORT_PAD(SHORT_PAD),
    .LONG_PAD (LONG_PAD)
  ) u_pad_sel (
    .mode_i(pad_mode_i),
    .app_i (crc_app_i),
    .vlan_i(vlan),
    .tgt_o (pad_tgt)
  );

  assign need_pad    = 32'(pad_tgt) > n_now;
  assign eff         = need_pad ? 32'(pad_tgt) : n_now;
  assign len_err_now = len_chk_i && typ_cur_ok && (32'(typ_cur) <= LEN_MAX_VAL) &&
                       (32'(typ_cur) + MAC_HDR + (crc_app_i ? 32'd0 : FCS_BYTES) != eff);

  assign crc_en  = ((state_q == ST_BODY) && s_fire && !in_hdr && !over) ||
                   ((state_q == ST_PAD) && m_fire);
  assign crc_clr = (state_q == ST_STAT);

  tx_crc32 u_crc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (crc_clr),
    .en_i     (crc_en),
    .data_i   ((state_q == ST_PAD) ? 8'h00 : s_data_i),
    .crc_o    (crc_q),
    .crc_nxt_o(crc_nxt)
  );

  assign crc_err_now = !crc_app_i && (crc_nxt != CRC_RESIDUE);
  assign fcs_word    = ~crc_q;

  always_comb begin
    s_ready_o = 1'b0;
    m_valid_o = 1'b0;
    m_data_o  = 8'h00;
    m_last_o  = 1'b0;
    unique case (state_q)
      ST_BODY: begin
        s_ready_o = over ? 1'b1 : m_ready_i;
        m_valid_o = s_valid_i && !over;
        m_data_o  = s_data_i;
        m_last_o  = s_last_i && !crc_app_i;
      end
      ST_PAD: m_valid_o = 1'b1;
      ST_FCS: begin
        m_valid_o = 1'b1;
        m_data_o  = fcs_word[{fcs_idx_q, 3'b000} +: 8];
        m_last_o  = (fcs_idx_q == 2'd3);
      end
      ST_DROP: s_ready_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_BODY;
      hdr_cnt_q      <= '0;
      body_cnt_q     <= '0;
      typ_hi_q       <= '0;
      typ_q          <= '0;
      typ_ok_q       <= 1'b0;
      fcs_idx_q      <= '0;
      pad_tgt_q      <= '0;
      pend_len_q     <= '0;
      pend_crc_err_q <= 1'b0;
      pend_len_err_q <= 1'b0;
      pend_abort_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_BODY: if (s_fire) begin
          if (in_hdr) hdr_cnt_q <= hdr_cnt_q + 1'b1;
          else if (!over) begin
            body_cnt_q <= body_cnt_q + 1'b1;
            if (32'(body_cnt_q) == TYPE_OFS) typ_hi_q <= s_data_i;
            if (typ_at_end) begin
              typ_q    <= {typ_hi_q, s_data_i};
              typ_ok_q <= 1'b1;
            end
          end
          if (over) begin
            pend_len_q     <= body_cnt_q;
            pend_crc_err_q <= 1'b0;
            pend_len_err_q <= 1'b0;
            pend_abort_q   <= 1'b1;
            state_q        <= s_last_i ? ST_STAT : ST_DROP;
          end else if (s_last_i) begin
            pend_len_q     <= LEN_W'(eff + fcs_room);
            pend_crc_err_q <= crc_err_now;
            pend_len_err_q <= len_err_now;
            pend_abort_q   <= 1'b0;
            pad_tgt_q      <= pad_tgt;
            state_q        <= need_pad ? ST_PAD : (crc_app_i ? ST_FCS : ST_STAT);
          end
        end
        ST_PAD: if (m_fire) begin
          body_cnt_q <= body_cnt_q + 1'b1;
          if (32'(body_cnt_q) + 32'd1 >= 32'(pad_tgt_q)) state_q <= ST_FCS;
        end
        ST_FCS: if (m_fire) begin
          fcs_idx_q <= fcs_idx_q + 1'b1;
          if (fcs_idx_q == 2'd3) state_q <= ST_STAT;
        end
        ST_DROP: if (s_fire && s_last_i) state_q <= ST_STAT;
        default: begin
          hdr_cnt_q  <= '0;
          body_cnt_q <= '0;
          typ_ok_q   <= 1'b0;
          fcs_idx_q  <= '0;
          state_q    <= ST_BODY;
        end
      endcase
    end
  end

  assign stat_valid_o   = (state_q == ST_STAT);
  assign stat_len_o     = pend_len_q;
  assign stat_crc_err_o = pend_crc_err_q;
  assign stat_len_err_o = pend_len_err_q;
  assign stat_abort_o   = pend_abort_q;

  // R1: FCS never starts before the pad target is reached
  a_r1_pad_reached: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FCS) |-> (32'(body_cnt_q) >= 32'(pad_tgt_q)));

  // R8: appended FCS stays inside the limit when the pad target fits
  a_r8_limit_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!huge_en_i && (state_q == ST_FCS) && (32'(max_len_i) >= LONG_PAD + FCS_BYTES))
      |-> (32'(body_cnt_q) + FCS_BYTES <= 32'(max_len_i)));

  // R11: single-cycle status pulse
  a_r11_stat_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o);

  // R11: status follows the final output byte
  a_r11_stat_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_ready_i && m_last_o) |=> stat_valid_o);

  // R12: generated bytes held under back-pressure
  a_r12_hold_gen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_PAD || state_q == ST_FCS) && m_valid_o && !m_ready_i)
      |=> (m_valid_o && $stable(m_data_o)));
endmodule

// File: tb/tx_fcs_inserter_bench.sv
module tx_fcs_inserter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  s_data_i = 8'h00;
  logic        s_valid_i = 1'b0;
  logic        s_last_i = 1'b0;
  logic        s_ready_o;
  logic [7:0]  m_data_o;
  logic        m_valid_o;
  logic        m_last_o;
  logic        m_ready_i = 1'b1;
  logic [2:0]  pad_mode_i = 3'd0;
  logic        crc_app_i = 1'b1;
  logic        hdr_en_i = 1'b0;
  logic        huge_en_i = 1'b0;
  logic        len_chk_i = 1'b0;
  logic [15:0] max_len_i = 16'd1518;
  logic        stat_valid_o;
  logic [15:0] stat_len_o;
  logic        stat_crc_err_o, stat_len_err_o, stat_abort_o;

  always #5 clk_i = ~clk_i;

  tx_fcs_inserter u_tx_fcs_inserter (.*);

  typedef struct packed {
    logic [2:0]  mode;
    logic        app, hdr, huge, lchk, bp, bad;
    logic [15:0] maxl, plen, typ, olen;
    logic        ecrc, elen, eab;
    logic [4:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{3'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1518,16'd20,16'h0800,16'd64,1'b0,1'b0,1'b0,5'd1},  // R1
    '{3'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1518,16'd20,16'h0800,16'd68,1'b0,1'b0,1'b0,5'd2},  // R2
    '{3'd7,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,16'd1518,16'd70,16'h0800,16'd74,1'b0,1'b0,1'b0,5'd2},  // R2 long, stalled
    '{3'd5,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1518,16'd30,16'h8100,16'd68,1'b0,1'b0,1'b0,5'd3},  // R3 tagged
    '{3'd5,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1518,16'd30,16'h0800,16'd64,1'b0,1'b0,1'b0,5'd3},  // R3 untagged
    '{3'd5,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1518,16'd13,16'h8100,16'd64,1'b0,1'b0,1'b0,5'd3},  // R3 cut type
    '{3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1518,16'd20,16'h0800,16'd24,1'b0,1'b0,1'b0,5'd5},  // R5
    '{3'd6,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1518,16'd20,16'h0800,16'd24,1'b0,1'b0,1'b0,5'd4},  // R4
    '{3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1518,16'd30,16'h0800,16'd30,1'b0,1'b0,1'b0,5'd4},  // R4 no append
    '{3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1518,16'd40,16'h0800,16'd40,1'b0,1'b0,1'b0,5'd6},  // R6 good
    '{3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,16'd1518,16'd40,16'h0800,16'd40,1'b1,1'b0,1'b0,5'd6},  // R6 bad
    '{3'd1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'd1518,16'd20,16'h0800,16'd64,1'b0,1'b0,1'b0,5'd7},  // R7
    '{3'd1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'd1518,16'd20,16'h002E,16'd64,1'b0,1'b0,1'b0,5'd10}, // R10 padded match
    '{3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'd1518,16'd40,16'h0010,16'd44,1'b0,1'b1,1'b0,5'd10}, // R10 miss
    '{3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'd1518,16'd40,16'h0800,16'd44,1'b0,1'b0,1'b0,5'd10}, // R10 type
    '{3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'd1518,16'd40,16'h0016,16'd40,1'b0,1'b0,1'b0,5'd10}, // R10 carried FCS
    '{3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'd1518,16'd40,16'h05DC,16'd44,1'b0,1'b1,1'b0,5'd10}, // R10 1500
    '{3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'd1518,16'd40,16'h05DD,16'd44,1'b0,1'b0,1'b0,5'd10}, // R10 1501
    '{3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd64,  16'd70,16'h0800,16'd60,1'b0,1'b0,1'b1,5'd8},  // R8 drop tail
    '{3'd0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'd64,  16'd61,16'h0800,16'd65,1'b0,1'b0,1'b0,5'd9},  // R9
    '{3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd64,  16'd60,16'h0800,16'd64,1'b0,1'b0,1'b0,5'd8},  // R8 at limit
    '{3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'd64,  16'd65,16'h0800,16'd64,1'b0,1'b0,1'b1,5'd8},  // R8 carried FCS
    '{3'd0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,16'd64,  16'd61,16'h0800,16'd60,1'b0,1'b0,1'b1,5'd7}   // R7 header + abort
  };

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] pay [256];
  logic [7:0] exp_buf [256];
  logic [7:0] got_buf [4096];
  logic       got_last [4096];
  int         got_total = 0;
  int         stat_cnt = 0;
  int         stat_double = 0;
  logic       stat_prev = 1'b0;
  logic [15:0] st_len;
  logic        st_crc, st_lerr, st_ab;
  logic        bp_on = 1'b0;
  int          bp_cnt = 0;

  always @(negedge clk_i) begin
    if (m_valid_o && m_ready_i && got_total < 4096) begin
      got_buf[got_total]  = m_data_o;
      got_last[got_total] = m_last_o;
      got_total++;
    end
    if (stat_valid_o) begin
      stat_cnt++;
      st_len = stat_len_o; st_crc = stat_crc_err_o;
      st_lerr = stat_len_err_o; st_ab = stat_abort_o;
      if (stat_prev) stat_double++;
    end
    stat_prev = stat_valid_o;
  end

  always @(posedge clk_i) begin
    #1;
    bp_cnt++;
    m_ready_i = !bp_on || (bp_cnt % 3 != 0);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] crc_ref(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, pay[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic send_byte(input logic [7:0] d, input logic l);
    s_valid_i = 1'b1; s_data_i = d; s_last_i = l;
    do @(negedge clk_i); while (!s_ready_o);
    @(posedge clk_i); #1;
    s_valid_i = 1'b0; s_last_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int hb, p, base, sbase, nexp, nout, mism, nl, t, padded;
    logic [31:0] c;
    string rq;
    rq = $sformatf("R%0d", v.req);
    hb = v.hdr ? 4 : 0;
    p  = v.app ? int'(v.plen) : int'(v.plen) - 4;
    for (int i = 0; i < 256; i++) pay[i] = 8'h00;
    for (int i = 0; i < p; i++)
      pay[i] = (i == 12) ? v.typ[15:8] : (i == 13) ? v.typ[7:0] : 8'((i * 13 + 5) & 255);
    if (!v.app) begin
      c = crc_ref(p);
      for (int k = 0; k < 4; k++) pay[p + k] = c[8*k +: 8];
      if (v.bad) pay[p] = pay[p] ^ 8'h01;
    end
    for (int i = 0; i < hb; i++) exp_buf[i] = 8'(8'hA0 + i);
    if (v.eab || !v.app) begin
      for (int i = 0; i < int'(v.olen); i++) exp_buf[hb + i] = pay[i];
    end else begin
      padded = int'(v.olen) - 4;
      c = crc_ref(padded);
      for (int i = 0; i < padded; i++) exp_buf[hb + i] = pay[i];
      for (int k = 0; k < 4; k++) exp_buf[hb + padded + k] = c[8*k +: 8];
    end
    nexp = hb + int'(v.olen);
    @(posedge clk_i); #1;
    pad_mode_i = v.mode; crc_app_i = v.app; hdr_en_i = v.hdr; huge_en_i = v.huge;
    len_chk_i = v.lchk; max_len_i = v.maxl; bp_on = v.bp;
    base = got_total; sbase = stat_cnt;
    for (int i = 0; i < hb; i++) send_byte(8'(8'hA0 + i), 1'b0);
    for (int i = 0; i < int'(v.plen); i++) send_byte(pay[i], i == int'(v.plen) - 1);
    t = 0;
    while (stat_cnt == sbase && t < 3000) begin @(posedge clk_i); t++; end
    @(negedge clk_i);
    nout = got_total - base;
    chk(nout == nexp, rq, "output byte count", nout, nexp);
    mism = -1; nl = 0;
    for (int i = 0; i < nout && i < nexp; i++) begin
      if (mism < 0 && got_buf[base + i] != exp_buf[i]) mism = i;
      if (got_last[base + i]) nl++;
    end
    chk(mism < 0, rq, "first mismatching byte index", mism, -1);
    if (v.eab) chk(nl == 0, rq, "last flags on aborted frame", nl, 0);
    else chk(nl == 1 && nout > 0 && got_last[base + nout - 1], rq, "last flag on final byte", nl, 1);
    chk(stat_cnt == sbase + 1, rq, "status pulses", stat_cnt - sbase, 1);
    chk(st_len == v.olen, rq, "status length", int'(st_len), int'(v.olen));
    chk(st_crc == v.ecrc, rq, "status crc error", int'(st_crc), int'(v.ecrc));
    chk(st_lerr == v.elen, rq, "status length error", int'(st_lerr), int'(v.elen));
    chk(st_ab == v.eab, rq, "status abort", int'(st_ab), int'(v.eab));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R0 watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!m_valid_o, "R13", "m_valid during reset", int'(m_valid_o), 0);
    chk(!stat_valid_o, "R13", "stat_valid during reset", int'(stat_valid_o), 0);
    @(posedge clk_i); #1; rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!m_valid_o, "R13", "m_valid after reset", int'(m_valid_o), 0);
    chk(!stat_valid_o, "R13", "stat_valid after reset", int'(stat_valid_o), 0);
    chk(s_ready_o == m_ready_i, "R12", "ready pass-through idle", int'(s_ready_o), int'(m_ready_i));

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // directed: back-to-back repeat of a stalled padded frame
    run_vec('{3'd3,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,16'd1518,16'd5,16'h0800,16'd68,1'b0,1'b0,1'b0,5'd12});
    // directed: header-only frame with header mode, no pad
    run_vec('{3'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'd1518,16'd1,16'h0800,16'd5,1'b0,1'b0,1'b0,5'd7});

    chk(stat_double == 0, "R11", "multi-cycle status pulses", stat_double, 0);
    chk(stat_cnt == NV + 2, "R11", "total status pulses", stat_cnt, NV + 2);
    @(negedge clk_i);
    chk(!m_valid_o && !stat_valid_o, "R13", "idle after traffic", int'(m_valid_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule